// File: doc/BRIEF.md
# Dual-Strobe Edge-Triggered Four-Bit Counter

This block is a four-bit up counter that steps on either of two input events. The first event is a rising edge on the count clock input while the count enable input is high. The second is a falling edge on the count enable input while the count clock input is low. Because of the second event, the most significant output bit of one stage can drive the enable input of the next stage. The next stage then advances when the first stage rolls over, and stages can be chained in a ripple fashion.

A parameter chosen at elaboration makes the counter either a decade counter (0 to 9) or a modulo-16 binary counter. The count clock, count enable and clear inputs are asynchronous pins. Each passes through a synchroniser into the fast system clock domain, and edges are found by comparing each sample with the one before it. A high clear input returns the count to zero. A terminal-count flag shows when the count sits at its top value.

Top module: `edge_counter4`

## Requirements
- R1: With the count enable sampled high, a rising edge on the count clock input increments the count by one.
- R2: With the count clock sampled low, a falling edge on the count enable input increments the count by one.
- R3: These events leave the count unchanged: a falling edge on the count clock, a rising edge on the count enable, a count clock rise while enable is low, and an enable fall while the count clock is high.
- R4: While the synchronised clear is high, the count is zero. A strobe that arrives in the same cycle as the clear is discarded.
- R5: In binary mode (MODE = MODE_BINARY) the count wraps from 15 to 0.
- R6: In decade mode (MODE = MODE_DECADE) the count wraps from 9 to 0 and never shows a code above 9.
- R7: In decade mode the successor of each illegal code is: 10 gives 11, 11 gives 4, 12 gives 13, 13 gives 4, 14 gives 15, 15 gives 4. Any illegal code therefore reaches a legal one within two counting events.
- R8: The terminal-count output is high exactly when the count equals 9 in decade mode or 15 in binary mode.
- R9: If a qualifying count clock rise and a qualifying enable fall appear in the same sample, the count advances by one only.
- R10: After system reset, the count is zero and the terminal-count output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_clk_i | input | 1 | Asynchronous count clock input |
| cnt_en_i | input | 1 | Asynchronous count enable input, also usable as a falling-edge strobe |
| clear_i | input | 1 | Asynchronous active-high clear |
| q_o | output | 4 | Count value, bit 0 least significant |
| tc_o | output | 1 | High when the count is at its top value |

## Verification
The clear and a count strobe can land in the same system cycle. They pass through synchronisers of equal depth, so raising clear_i and the count clock input on the same bench edge makes both reach the counter together. The count must then read zero rather than one. The same construction is used for the two strobes together: the count clock rises while the enable falls, and the bench expects a single step, not two.

// File: rtl/edge_counter4_pkg.sv
package edge_counter4_pkg;

    localparam int CNT_W = 4;

    typedef enum logic {
        MODE_BINARY = 1'b0,
        MODE_DECADE = 1'b1
    } count_mode_e;

    typedef logic [CNT_W-1:0] code_t;

    typedef struct packed {
        logic clk_lvl;
        logic en_lvl;
    } strobe_pair_t;

    function automatic code_t top_code(count_mode_e m);
        return (m == MODE_DECADE) ? code_t'(9) : code_t'(15);
    endfunction

    function automatic code_t next_code(count_mode_e m, code_t q);
        code_t n;
        n = q + code_t'(1);
        if (m == MODE_DECADE) begin
            case (q)
                code_t'(9):  n = code_t'(0);
                code_t'(11),
                code_t'(13),
                code_t'(15): n = code_t'(4);
                default:     n = q + code_t'(1);
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/ec4_sync.sv
module ec4_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ec4_strobe_detect.sv
module ec4_strobe_detect
    import edge_counter4_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  strobe_pair_t now_i,
    output logic         inc_o
);
    strobe_pair_t prev;
    logic clk_rise_q, en_fall_q;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= now_i;
    end

    // Qualifier levels come from the previous sample, so simultaneous
    // opposite edges are both judged against the settled state.
    assign clk_rise_q = now_i.clk_lvl & ~prev.clk_lvl &  prev.en_lvl;
    assign en_fall_q  = prev.en_lvl  & ~now_i.en_lvl  & ~prev.clk_lvl;
    assign inc_o      = clk_rise_q | en_fall_q;
endmodule

// File: rtl/ec4_count_core.sv
module ec4_count_core
    import edge_counter4_pkg::*;
#(
    parameter count_mode_e MODE = MODE_DECADE
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  logic  inc_i,
    output code_t q_o,
    output logic  tc_o
);
    code_t q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) q <= '0;
        else if (inc_i)   q <= next_code(MODE, q);
    end

    assign q_o  = q;
    assign tc_o = (q == top_code(MODE));
endmodule

// File: rtl/edge_counter4.sv
module edge_counter4
    import edge_counter4_pkg::*;
#(
    parameter count_mode_e MODE        = MODE_DECADE,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_clk_i,
    input  logic       cnt_en_i,
    input  logic       clear_i,
    output logic [3:0] q_o,
    output logic       tc_o
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_in, synced;
    strobe_pair_t      lvl;
    logic              clr_s;
    logic              inc;
    code_t             q;

    assign raw_in = {clear_i, cnt_en_i, cnt_clk_i};

    ec4_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (synced)
    );

    assign lvl.clk_lvl = synced[0];
    assign lvl.en_lvl  = synced[1];
    assign clr_s       = synced[2];

    ec4_strobe_detect u_det (
        .clk   (clk),
        .rst   (rst),
        .now_i (lvl),
        .inc_o (inc)
    );

    ec4_count_core #(.MODE(MODE)) u_core (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_s),
        .inc_i (inc),
        .q_o   (q),
        .tc_o  (tc_o)
    );

    assign q_o = q;
endmodule

// File: rtl/edge_counter4_checker.sv
module edge_counter4_checker
    import edge_counter4_pkg::*;
#(
    parameter count_mode_e MODE = MODE_DECADE
) (
    input logic       clk,
    input logic       rst,
    input logic       clr_s,
    input logic       inc,
    input logic [3:0] q,
    input logic       tc
);
    localparam code_t TOP = top_code(MODE);

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
        clr_s |=> (q == 4'd0));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr_s) |=> $stable(q));

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr_s && q < TOP) |=> (q == 4'($past(q) + 4'd1)));

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr_s && q == TOP) |=> (q == 4'd0));

    p_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        q <= TOP);

    p_tc_top_r8: assert property (@(posedge clk) disable iff (rst)
        tc |-> (q == TOP));
endmodule

bind edge_counter4 edge_counter4_checker #(.MODE(MODE)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .clr_s (clr_s),
    .inc   (inc),
    .q     (q_o),
    .tc    (tc_o)
);

// File: tb/edge_counter4_tb.sv
module edge_counter4_tb;
    import edge_counter4_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cclk = 1'b0, cen = 1'b0, clr = 1'b0;
    logic [3:0] q_dec, q_bin;
    logic tc_dec, tc_bin;
    int n_chk = 0, n_bad = 0;
    int e_dec = 0, e_bin = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    edge_counter4 #(.MODE(MODE_DECADE)) u_dut (
        .clk(clk), .rst(rst), .cnt_clk_i(cclk), .cnt_en_i(cen),
        .clear_i(clr), .q_o(q_dec), .tc_o(tc_dec));

    edge_counter4 #(.MODE(MODE_BINARY)) u_bin (
        .clk(clk), .rst(rst), .cnt_clk_i(cclk), .cnt_en_i(cen),
        .clear_i(clr), .q_o(q_bin), .tc_o(tc_bin));

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_both(string req);
        check(req, int'(q_dec), e_dec);
        check(req, int'(q_bin), e_bin);
        check({req, " R8"}, int'(tc_dec), int'(e_dec == 9));
        check({req, " R8"}, int'(tc_bin), int'(e_bin == 15));
    endtask

    task automatic drive(logic c, logic e, logic r);
        @(negedge clk);
        cclk = c; cen = e; clr = r;
        repeat (4) @(negedge clk);
    endtask

    task automatic bump();
        e_dec = (e_dec == 9) ? 0 : e_dec + 1;
        e_bin = (e_bin + 1) % 16;
    endtask

    task automatic t_reset_r10();
        check_both("R10 reset");
    endtask

    task automatic t_clk_rise_r1();
        drive(1'b0, 1'b1, 1'b0);
        check_both("R1 enable raise alone");
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 1'b1, 1'b0); bump();
            check_both("R1 clock rise");
            drive(1'b0, 1'b1, 1'b0);
            check_both("R3 clock fall");
        end
    endtask

    task automatic t_en_fall_r2();
        for (int i = 0; i < 2; i++) begin
            drive(1'b0, 1'b0, 1'b0); bump();
            check_both("R2 enable fall");
            drive(1'b0, 1'b1, 1'b0);
            check_both("R3 enable rise");
        end
    endtask

    task automatic t_ignored_r3();
        drive(1'b0, 1'b0, 1'b0); bump();
        drive(1'b1, 1'b0, 1'b0);
        check_both("R3 clock rise, enable low");
        drive(1'b1, 1'b1, 1'b0);
        check_both("R3 enable rise, clock high");
        drive(1'b1, 1'b0, 1'b0);
        check_both("R3 enable fall, clock high");
        drive(1'b0, 1'b0, 1'b0);
        check_both("R3 clock fall, enable low");
    endtask

    task automatic t_double_r9();
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b1, 1'b0, 1'b0); bump();
        check_both("R9 both strobes together");
        drive(1'b0, 1'b0, 1'b0);
        check_both("R9 settle");
    endtask

    task automatic t_wrap_r5_r6();
        drive(1'b0, 1'b1, 1'b0);
        while (e_bin != 15) begin
            drive(1'b0, 1'b0, 1'b0); bump();
            drive(1'b0, 1'b1, 1'b0);
            if (e_dec == 9) check_both("R6 decade top");
        end
        check_both("R5 binary top");
        drive(1'b0, 1'b0, 1'b0); bump();
        check_both("R5 R6 wrap");
    endtask

    task automatic t_clear_r4();
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b1, 1'b1, 1'b1);
        e_dec = 0; e_bin = 0;
        check_both("R4 clear with strobe");
        drive(1'b0, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 1'b1);
        check_both("R4 strobe under clear");
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b1, 1'b1, 1'b0); bump();
        check_both("R4 count after release");
    endtask

    task automatic t_illegal_r7();
        int exp_map [6] = '{11, 4, 13, 4, 15, 4};
        for (int c = 10; c < 16; c++) begin
            check("R7 successor", int'(next_code(MODE_DECADE, 4'(c))), exp_map[c-10]);
            check("R7 two-step bound",
                  int'(next_code(MODE_DECADE, next_code(MODE_DECADE, 4'(c))) <= 4'd9), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset_r10();
        t_clk_rise_r1();
        t_en_fall_r2();
        t_ignored_r3();
        t_double_r9();
        t_wrap_r5_r6();
        t_clear_r4();
        t_illegal_r7();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule